// File: doc/BRIEF.md
# Transmit XON/XOFF Flow Gate

This block sits between a transmit character queue and the serial shifter and applies in-band software flow control to the outgoing stream. It watches every character the receiver delivers. When flow control is on and the stop code (0x13, ctrl-S) arrives, it enters a paused state. In that state it withholds permission to load new characters into the transmit holding register.

Characters already sitting in the holding register or the shift register are not touched and drain normally. At most two characters therefore leave the line after the stop code. The pause ends in one of three ways:

- the resume code (0x11, ctrl-Q) arrives;
- in resume-on-any mode, any received character arrives;
- the host issues a transmit-enable command pulse.

Clearing the enable bit also lifts the pause.

Top module: `txflow_gate`

## Requirements
- R1: A synchronous active-high `rst` clears the paused state: after the reset edge `paused` is 0 and `load_ok` is 1 while no stop code is being presented.
- R2: While `flow_en` is 0, no received character pauses transmission, and `resume_any` has no effect. Dropping `flow_en` to 0 while paused makes `paused` 0 after the next rising clock edge.
- R3: With `flow_en` at 1, a strobe (`rx_valid` high) carrying `rx_data` = 0x13 sets `paused` to 1 after that clock edge.
- R4: `load_ok` is 0 whenever `paused` is 1. It is also 0 in the very cycle that an enabled stop code is presented, so no new character is loaded after the stop code. Characters already loaded are left to drain, bounding the overrun to two.
- R5: With `resume_any` at 0, only a strobe carrying 0x11 ends a pause (`paused` 0 after the edge). Other received characters leave it paused.
- R6: With `resume_any` at 1, a strobe carrying any character other than 0x13 ends a pause after the edge.
- R7: A one-cycle `host_tx_en` pulse ends a pause in either resume mode. If an enabled stop code is presented in the same cycle, the stop code wins and the block stays paused.
- R8: A stop code received while already paused keeps the block paused. A resume code received while not paused changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| flow_en | input | 1 | In-band flow control enable |
| resume_any | input | 1 | 1: any received character resumes; 0: only 0x11 resumes |
| host_tx_en | input | 1 | Host transmit-enable command pulse |
| rx_valid | input | 1 | Received-character strobe, one cycle per character |
| rx_data | input | 8 | Received character |
| paused | output | 1 | Transmission is paused by flow control |
| load_ok | output | 1 | Transmit path may load a new character into the holding register |

## Verification
The two outputs follow different timing, and the checks sample each one where it is due.

- `load_ok` responds in the same cycle the stop code is presented, because it decodes the stop code combinationally. It is compared at the falling edge of that same cycle.
- `paused` is a register, so a change caused by a strobe, command or enable change appears one rising edge later.

For each cycle, the driver pushes the model's expected state of `paused` before that edge. It pushes it together with the expected `load_ok` for the inputs being presented. The monitor pops exactly one entry at each falling edge. As a result, a one-cycle slip in either output shows up as a mismatch.

// File: rtl/txflow_gate.sv
module txflow_gate #(
  parameter int unsigned         DW        = 8,
  parameter logic [DW-1:0]       STOP_CODE = 'h13,
  parameter logic [DW-1:0]       GO_CODE   = 'h11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flow_en,
  input  logic          resume_any,
  input  logic          host_tx_en,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          paused,
  output logic          load_ok
);

  logic stop_hit, go_hit, release_req, paused_q;

  assign stop_hit    = flow_en & rx_valid & (rx_data == STOP_CODE);
  assign go_hit      = rx_valid & (resume_any | (rx_data == GO_CODE));
  assign release_req = host_tx_en | go_hit;

  always_ff @(posedge clk) begin
    if (rst)             paused_q <= 1'b0;
    else if (!flow_en)   paused_q <= 1'b0;
    else if (stop_hit)   paused_q <= 1'b1;
    else if (release_req) paused_q <= 1'b0;
  end

  assign paused  = paused_q;
  assign load_ok = ~paused_q & ~stop_hit;

  // reset clears the pause
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !paused);

  p_disabled_free_r2: assert property (@(posedge clk) disable iff (rst)
    !flow_en |=> !paused);

  p_stop_pauses_r3: assert property (@(posedge clk) disable iff (rst)
    (flow_en && rx_valid && rx_data == STOP_CODE) |=> paused);

  p_gate_closed_r4: assert property (@(posedge clk) disable iff (rst)
    (paused || (flow_en && rx_valid && rx_data == STOP_CODE)) |-> !load_ok);

  p_only_go_r5: assert property (@(posedge clk) disable iff (rst)
    (paused && flow_en && !resume_any && !host_tx_en &&
     !(rx_valid && rx_data == GO_CODE)) |=> paused);

  p_any_resumes_r6: assert property (@(posedge clk) disable iff (rst)
    (paused && flow_en && resume_any && rx_valid && rx_data != STOP_CODE) |=> !paused);

  p_host_resumes_r7: assert property (@(posedge clk) disable iff (rst)
    (flow_en && host_tx_en && !(rx_valid && rx_data == STOP_CODE)) |=> !paused);

  p_no_spurious_pause_r8: assert property (@(posedge clk) disable iff (rst)
    (!paused && !(flow_en && rx_valid && rx_data == STOP_CODE)) |=> !paused);

endmodule

// File: tb/tb_txflow_gate.sv
module tb_txflow_gate;

  logic clk = 1'b0;
  logic rst, flow_en, resume_any, host_tx_en, rx_valid;
  logic [7:0] rx_data;
  logic paused, load_ok;

  always #2.5 clk = ~clk;

  txflow_gate dut (
    .clk(clk), .rst(rst), .flow_en(flow_en), .resume_any(resume_any),
    .host_tx_en(host_tx_en), .rx_valid(rx_valid), .rx_data(rx_data),
    .paused(paused), .load_ok(load_ok)
  );

  typedef struct {
    logic  p;
    logic  l;
    string tag;
  } exp_t;

  exp_t exq[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  logic m_p     = 1'b0;
  bit   done    = 1'b0;

  task automatic step(input logic r, input logic en, input logic any,
                      input logic host, input logic v, input logic [7:0] d,
                      input string tag);
    exp_t e;
    logic stop;
    @(posedge clk);
    #1;
    rst = r; flow_en = en; resume_any = any; host_tx_en = host;
    rx_valid = v; rx_data = d;
    stop  = en && v && (d == 8'h13);
    e.p   = m_p;
    e.l   = !m_p && !stop;
    e.tag = tag;
    exq.push_back(e);
    if (r || !en)                                    m_p = 1'b0;
    else if (stop)                                   m_p = 1'b1;
    else if (host || (v && (any || d == 8'h11)))     m_p = 1'b0;
  endtask

  always @(negedge clk) begin
    if (exq.size() > 0) begin
      exp_t e;
      e = exq.pop_front();
      n_tests++;
      if (paused !== e.p) begin
        n_fail++;
        $display("FAIL %s paused actual=%b expected=%b", e.tag, paused, e.p);
      end
      n_tests++;
      if (load_ok !== e.l) begin
        n_fail++;
        $display("FAIL %s load_ok actual=%b expected=%b", e.tag, load_ok, e.l);
      end
    end
  end

  initial begin
    rst = 1'b1; flow_en = 1'b0; resume_any = 1'b0; host_tx_en = 1'b0;
    rx_valid = 1'b0; rx_data = 8'h00;
    @(posedge clk);
    step(1, 0, 0, 0, 0, 8'h00, "R1");
    step(0, 0, 0, 0, 0, 8'h00, "R1");
    // disabled: stop code and mode bit ignored
    step(0, 0, 0, 0, 1, 8'h13, "R2");
    step(0, 0, 1, 0, 1, 8'h13, "R2");
    step(0, 0, 1, 0, 1, 8'h41, "R2");
    step(0, 0, 0, 0, 0, 8'h00, "R2");
    // enable, stop code
    step(0, 1, 0, 0, 1, 8'h13, "R3");
    step(0, 1, 0, 0, 0, 8'h00, "R4");
    step(0, 1, 0, 0, 1, 8'h41, "R5");
    step(0, 1, 0, 0, 1, 8'h13, "R8");
    step(0, 1, 0, 0, 1, 8'h11, "R5");
    step(0, 1, 0, 0, 1, 8'h11, "R8");
    step(0, 1, 0, 0, 0, 8'h00, "R8");
    // any-character mode
    step(0, 1, 1, 0, 1, 8'h13, "R3");
    step(0, 1, 1, 0, 1, 8'h13, "R8");
    step(0, 1, 1, 0, 1, 8'h41, "R6");
    step(0, 1, 1, 0, 0, 8'h00, "R6");
    step(0, 1, 1, 0, 1, 8'h13, "R3");
    step(0, 1, 1, 0, 1, 8'h00, "R6");
    // host command
    step(0, 1, 0, 0, 1, 8'h13, "R3");
    step(0, 1, 0, 1, 0, 8'h00, "R7");
    step(0, 1, 0, 0, 1, 8'h13, "R3");
    step(0, 1, 1, 1, 0, 8'h00, "R7");
    step(0, 1, 0, 1, 1, 8'h13, "R7");
    step(0, 1, 0, 0, 0, 8'h00, "R7");
    // disable while paused
    step(0, 0, 0, 0, 0, 8'h00, "R2");
    step(0, 0, 0, 0, 0, 8'h00, "R2");
    // reset while paused
    step(0, 1, 0, 0, 1, 8'h13, "R3");
    step(1, 1, 0, 0, 0, 8'h00, "R1");
    step(0, 1, 0, 0, 0, 8'h00, "R1");
    step(0, 1, 0, 0, 0, 8'h00, "R1");
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule